// File: doc/BRIEF.md
# Serial Ethernet Receive Frame Integrity Checker

This block watches a bit-serial Ethernet receive stream for the whole time that carrier sense is high. Data bits are taken only on cycles where the bit strobe is high while carrier is present. The block first checks the lead-in pattern. That pattern is an alternating one/zero run closed by two ones in a row. Any pair of zeros in that run ends the reception on the spot, and checking starts on the very first bit after carrier rises.

After the closing pair, every bit of the address, payload and frame check sequence goes through a serial CRC-32 register. Only whole octets count towards the final remainder. When carrier falls, the block issues a one-cycle verdict. The verdict says whether the frame is good, has a CRC error, has an alignment error (bad CRC plus 2 to 7 leftover bits), or was abandoned in the lead-in. It also says whether the frame should be kept, and it steps two saturating error counters.

A receive-with-errors control lets frames that fail the CRC be kept instead of dropped. Buffering, address matching and the physical layer belong to the surrounding receive path.

Top module: `eth_rx_integrity`

## Requirements
- R1: After reset, all verdict outputs are 0 and both error counters are 0.
- R2: A lead-in of alternating bits 1,0 closed by 1,1 followed by a correct frame gives, on the cycle after the first clock edge that sees carrier low, a one-cycle frame_done with frame_ok=1 and crc_err, align_err and pre_abort at 0. Outside frame_done, every verdict output is 0.
- R3: Two consecutive 0 bits anywhere in the lead-in, including the first two bits after carrier rises, abort the reception. The remaining bits are ignored. At carrier drop, frame_done comes with pre_abort=1, and frame_ok, frame_keep, crc_err and align_err are all 0. Neither counter changes.
- R4: If carrier falls before the closing 1,1 pair is seen, the result is the same as in R3.
- R5: The CRC uses the polynomial 0x04C11DB7. The register is preset to all ones when the closing pair is seen, and bits enter in wire order (each octet least significant bit first). A frame passes when the register value after the last whole octet is 0xC704DD7B. Otherwise crc_err=1, frame_ok=0, and the CRC error counter goes up by 1.
- R6: Bits after the last whole octet (1 to 7 of them) are left out of the CRC, so a correct frame followed by such bits still gives frame_ok=1.
- R7: When the CRC fails and 2 to 7 bits of a partial octet were received, align_err=1 as well as crc_err, and the alignment counter goes up by 1. With 0 or 1 leftover bits, align_err stays 0.
- R8: frame_keep is 1 for a passing frame. It is also 1 for a CRC-failing frame when rx_with_errors is 1 at carrier drop. In every other case it is 0.
- R9: Each error counter is CNT_W bits wide and holds at 2^CNT_W-1 instead of wrapping.
- R10: rx_bit is sampled only when rx_strobe and carrier are both high, so changes of rx_bit between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier | input | 1 | Carrier sense; high for the whole reception |
| rx_strobe | input | 1 | One-cycle strobe marking a valid rx_bit |
| rx_bit | input | 1 | Serial receive data |
| rx_with_errors | input | 1 | Keep frames that fail the CRC |
| frame_done | output | 1 | One-cycle verdict strobe after carrier drop |
| frame_ok | output | 1 | Frame passed the CRC |
| frame_keep | output | 1 | Frame should be passed on |
| crc_err | output | 1 | CRC remainder mismatch |
| align_err | output | 1 | CRC mismatch with 2 to 7 leftover bits |
| pre_abort | output | 1 | Reception ended in the lead-in |
| crc_err_cnt | output | CNT_W | Saturating CRC error count |
| align_err_cnt | output | CNT_W | Saturating alignment error count |

## Verification
A CRC failure and an alignment failure are reported in the same frame_done cycle, and both counters step on the same edge. The bench provokes this by sending a frame with a corrupted check sequence followed by four extra bits. It judges the result by both flags appearing together and both counts rising by exactly one. The same pairing is then driven past saturation, and both counters are required to stop together at their ceiling. Corrupted frames with zero or one leftover bits form the control group: there, only the CRC side may move.

// File: rtl/eth_rxi_pkg.sv
package eth_rxi_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_LEAD = 2'd1,
    RX_BODY = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;

  localparam int unsigned CRC_W       = 32;
  localparam int unsigned OCTET_BITS  = 8;
  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

endpackage

// File: rtl/rxi_crc_serial.sv
module rxi_crc_serial #(
  parameter int unsigned W        = 32,
  parameter int unsigned OCT_W    = 8,
  parameter logic [W-1:0] POLY    = 32'h04C1_1DB7,
  parameter logic [W-1:0] INIT    = '1,
  localparam int unsigned IDX_W   = $clog2(OCT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             shift_en,
  input  logic             din,
  output logic [W-1:0]     snap_q,
  output logic [IDX_W-1:0] idx_q
);

  logic [W-1:0]     crc_q, crc_d, shifted;
  logic [W-1:0]     snap_d;
  logic [IDX_W-1:0] idx_d;
  logic             fb;

  assign fb = crc_q[W-1] ^ din;

  for (genvar g = 0; g < W; g++) begin : g_lfsr
    if (g == 0) begin : g_low
      assign shifted[g] = POLY[g] & fb;
    end else begin : g_up
      assign shifted[g] = crc_q[g-1] ^ (POLY[g] & fb);
    end
  end

  always_comb begin
    crc_d  = crc_q;
    snap_d = snap_q;
    idx_d  = idx_q;
    if (preset) begin
      crc_d  = INIT;
      snap_d = INIT;
      idx_d  = '0;
    end else if (shift_en) begin
      crc_d = shifted;
      if (idx_q == IDX_W'(OCT_W - 1)) begin
        idx_d  = '0;
        snap_d = shifted;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= INIT;
      snap_q <= INIT;
      idx_q  <= '0;
    end else begin
      crc_q  <= crc_d;
      snap_q <= snap_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/rxi_lead_check.sv
module rxi_lead_check (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_en,
  input  logic din,
  output logic sfd_seen,
  output logic zero_pair
);

  logic prev_q, prev_d;
  logic have_q, have_d;

  assign sfd_seen  = bit_en & have_q &  prev_q &  din;
  assign zero_pair = bit_en & have_q & ~prev_q & ~din;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (clear) begin
      have_d = 1'b0;
      prev_d = 1'b0;
    end else if (bit_en) begin
      have_d = 1'b1;
      prev_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

endmodule

// File: rtl/rxi_sat_counter.sv
module rxi_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc && (count != TOP)) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/eth_rx_integrity.sv
module eth_rx_integrity
  import eth_rxi_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier,
  input  logic             rx_strobe,
  input  logic             rx_bit,
  input  logic             rx_with_errors,
  output logic             frame_done,
  output logic             frame_ok,
  output logic             frame_keep,
  output logic             crc_err,
  output logic             align_err,
  output logic             pre_abort,
  output logic [CNT_W-1:0] crc_err_cnt,
  output logic [CNT_W-1:0] align_err_cnt
);

  localparam int unsigned IDX_W = $clog2(OCTET_BITS);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rx_state_e st_q, st_d;
  logic      bit_en, lead_window, lead_bit_en;
  logic      sfd_seen, zero_pair;
  logic      crc_preset, crc_shift;
  logic [CRC_W-1:0] snap;
  logic [IDX_W-1:0] tail_bits;

  assign bit_en      = rx_strobe & carrier;
  assign lead_window = carrier & ((st_q == RX_IDLE) | (st_q == RX_LEAD));
  assign lead_bit_en = bit_en & lead_window;
  assign crc_preset  = (st_q == RX_LEAD) & sfd_seen;
  assign crc_shift   = (st_q == RX_BODY) & bit_en;

  rxi_lead_check u_lead (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (~lead_window),
    .bit_en    (lead_bit_en),
    .din       (rx_bit),
    .sfd_seen  (sfd_seen),
    .zero_pair (zero_pair)
  );

  rxi_crc_serial #(
    .W     (CRC_W),
    .OCT_W (OCTET_BITS),
    .POLY  (CRC_POLY),
    .INIT  (CRC_INIT)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .preset   (crc_preset),
    .shift_en (crc_shift),
    .din      (rx_bit),
    .snap_q   (snap),
    .idx_q    (tail_bits)
  );

  // state next
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_IDLE: if (carrier) st_d = RX_LEAD;
      RX_LEAD: begin
        if (!carrier)       st_d = RX_IDLE;
        else if (zero_pair) st_d = RX_SKIP;
        else if (sfd_seen)  st_d = RX_BODY;
      end
      RX_BODY: if (!carrier) st_d = RX_IDLE;
      RX_SKIP: if (!carrier) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= RX_IDLE;
    else             st_q <= st_d;
  end

  // verdict next
  logic end_evt, body_end, residue_ok;
  logic done_d, ok_d, keep_d, crc_d, align_d, abort_d;

  assign end_evt    = (st_q != RX_IDLE) & ~carrier;
  assign body_end   = end_evt & (st_q == RX_BODY);
  assign residue_ok = (snap == CRC_RESIDUE);

  always_comb begin
    done_d  = end_evt;
    ok_d    = body_end & residue_ok;
    crc_d   = body_end & ~residue_ok;
    align_d = crc_d & (tail_bits > IDX_W'(1));
    abort_d = end_evt & (st_q != RX_BODY);
    keep_d  = ok_d | (crc_d & rx_with_errors);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      frame_keep <= 1'b0;
      crc_err    <= 1'b0;
      align_err  <= 1'b0;
      pre_abort  <= 1'b0;
    end else begin
      frame_done <= done_d;
      frame_ok   <= ok_d;
      frame_keep <= keep_d;
      crc_err    <= crc_d;
      align_err  <= align_d;
      pre_abort  <= abort_d;
    end
  end

  rxi_sat_counter #(.W(CNT_W)) u_crc_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (crc_d),
    .count (crc_err_cnt)
  );

  rxi_sat_counter #(.W(CNT_W)) u_align_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (align_d),
    .count (align_err_cnt)
  );

endmodule

// File: rtl/eth_rx_integrity_chk.sv
module eth_rx_integrity_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             carrier,
  input logic             frame_done,
  input logic             frame_ok,
  input logic             frame_keep,
  input logic             crc_err,
  input logic             align_err,
  input logic             pre_abort,
  input logic [CNT_W-1:0] crc_err_cnt,
  input logic [CNT_W-1:0] align_err_cnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_after_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !$past(carrier));

  assert_flags_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> !(frame_ok | frame_keep | crc_err | align_err | pre_abort));

  assert_ok_vs_crc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !(frame_ok && crc_err));

  assert_abort_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_abort |-> (!crc_err && !frame_ok && !frame_keep && !align_err));

  assert_align_has_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> crc_err);

  assert_keep_on_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> frame_keep);

  assert_crc_cnt_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_cnt != $past(crc_err_cnt)) |-> crc_err);

  assert_align_cnt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err_cnt != $past(align_err_cnt)) |-> align_err);

  assert_crc_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_cnt == CNT_TOP) |=> (crc_err_cnt == CNT_TOP));

  assert_align_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err_cnt == CNT_TOP) |=> (align_err_cnt == CNT_TOP));

endmodule

bind eth_rx_integrity eth_rx_integrity_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier       (carrier),
  .frame_done    (frame_done),
  .frame_ok      (frame_ok),
  .frame_keep    (frame_keep),
  .crc_err       (crc_err),
  .align_err     (align_err),
  .pre_abort     (pre_abort),
  .crc_err_cnt   (crc_err_cnt),
  .align_err_cnt (align_err_cnt)
);

// File: tb/tb_eth_rx_integrity.sv
`timescale 1ns/1ps
module tb_eth_rx_integrity;

  localparam int unsigned CNT_W   = 4;
  localparam int          CNT_MAX = (1 << CNT_W) - 1;

  logic clk, rst_n, carrier, rx_strobe, rx_bit, rx_with_errors;
  logic frame_done, frame_ok, frame_keep, crc_err, align_err, pre_abort;
  logic [CNT_W-1:0] crc_err_cnt, align_err_cnt;

  eth_rx_integrity #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .rx_strobe(rx_strobe),
    .rx_bit(rx_bit), .rx_with_errors(rx_with_errors),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_keep(frame_keep),
    .crc_err(crc_err), .align_err(align_err), .pre_abort(pre_abort),
    .crc_err_cnt(crc_err_cnt), .align_err_cnt(align_err_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int exp_crc_cnt = 0;
  int exp_aln_cnt = 0;

  logic wire_bits [0:1023];
  int   wire_len;

  // captured verdict
  logic c_done, c_ok, c_keep, c_crc, c_aln, c_abt;
  int   c_crc_cnt, c_aln_cnt;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    wire_bits[wire_len] = b;
    wire_len++;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
  endtask

  task automatic put_lead();
    for (int i = 0; i < 7; i++) put_byte(8'h55);
    put_byte(8'hD5);
  endtask

  // payload bytes from seed, then check sequence (optionally corrupted)
  task automatic put_body(input int n, input int seed, input logic [31:0] corrupt);
    logic [31:0] c;
    logic [7:0]  d;
    logic [31:0] fcs;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      d = 8'((seed * 37 + k * 91 + 5) & 8'hFF);
      put_byte(d);
      c = c ^ {24'h0, d};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    fcs = ~c ^ corrupt;
    put_byte(fcs[7:0]);
    put_byte(fcs[15:8]);
    put_byte(fcs[23:16]);
    put_byte(fcs[31:24]);
  endtask

  task automatic put_tail(input int n);
    for (int i = 0; i < n; i++) put_bit(i[0]);
  endtask

  // drive the wire image, drop carrier, capture the verdict
  task automatic transmit();
    @(negedge clk);
    carrier = 1'b1;
    for (int i = 0; i < wire_len; i++) begin
      rx_bit    = wire_bits[i];
      rx_strobe = 1'b1;
      @(negedge clk);
      rx_strobe = 1'b0;
      rx_bit    = ~wire_bits[i];
      @(negedge clk);
    end
    carrier = 1'b0;
    @(negedge clk);
    c_done = frame_done; c_ok = frame_ok; c_keep = frame_keep;
    c_crc = crc_err; c_aln = align_err; c_abt = pre_abort;
    c_crc_cnt = int'(crc_err_cnt); c_aln_cnt = int'(align_err_cnt);
    @(negedge clk);
    chk("R2", "done pulse width", int'(frame_done), 0);
    repeat (3) @(negedge clk);
    wire_len = 0;
  endtask

  task automatic bump(input logic crc_e, input logic aln_e);
    if (crc_e && exp_crc_cnt < CNT_MAX) exp_crc_cnt++;
    if (aln_e && exp_aln_cnt < CNT_MAX) exp_aln_cnt++;
  endtask

  task automatic expect_v(input string req, input logic ok, input logic keep,
                          input logic ce, input logic ae, input logic ab);
    bump(ce, ae);
    chk(req, "frame_done", int'(c_done), 1);
    chk(req, "frame_ok", int'(c_ok), int'(ok));
    chk(req, "frame_keep", int'(c_keep), int'(keep));
    chk(req, "crc_err", int'(c_crc), int'(ce));
    chk(req, "align_err", int'(c_aln), int'(ae));
    chk(req, "pre_abort", int'(c_abt), int'(ab));
    chk(req, "crc_err_cnt", c_crc_cnt, exp_crc_cnt);
    chk(req, "align_err_cnt", c_aln_cnt, exp_aln_cnt);
  endtask

  task automatic t_reset();
    chk("R1", "frame_done", int'(frame_done), 0);
    chk("R1", "flags", int'({frame_ok, frame_keep, crc_err, align_err, pre_abort}), 0);
    chk("R1", "crc_err_cnt", int'(crc_err_cnt), 0);
    chk("R1", "align_err_cnt", int'(align_err_cnt), 0);
  endtask

  task automatic t_good();  // R2 R5 R10 (bit line toggles between strobes)
    put_lead(); put_body(6, 1, 32'h0);
    transmit();
    expect_v("R2", 1, 1, 0, 0, 0);
  endtask

  task automatic t_good_tail(input int n);  // R6
    put_lead(); put_body(5, 2 + n, 32'h0); put_tail(n);
    transmit();
    expect_v("R6", 1, 1, 0, 0, 0);
  endtask

  task automatic t_bad(input int n);  // R5 with 0/1 tail, R7 with 2..7
    put_lead(); put_body(4, 9 + n, 32'h0000_0100); put_tail(n);
    transmit();
    if (n >= 2) expect_v("R7", 0, 0, 1, 1, 0);
    else        expect_v("R5", 0, 0, 1, 0, 0);
  endtask

  task automatic t_keep();  // R8
    rx_with_errors = 1'b1;
    put_lead(); put_body(4, 21, 32'h8000_0000);
    transmit();
    expect_v("R8", 0, 1, 1, 0, 0);
    put_lead(); put_body(4, 22, 32'h0);
    transmit();
    expect_v("R8", 1, 1, 0, 0, 0);
    rx_with_errors = 1'b0;
  endtask

  task automatic t_abort_mid();  // R3: zero pair inside lead-in
    put_bit(1); put_bit(0); put_bit(1); put_bit(0); put_bit(0);
    put_lead(); put_body(4, 30, 32'h1);
    transmit();
    expect_v("R3", 0, 0, 0, 0, 1);
  endtask

  task automatic t_abort_start();  // R3: first two bits zero
    put_bit(0); put_bit(0);
    put_lead(); put_body(4, 31, 32'h0);
    transmit();
    expect_v("R3", 0, 0, 0, 0, 1);
  endtask

  task automatic t_drop_lead();  // R4
    put_bit(1); put_bit(0); put_bit(1); put_bit(0); put_bit(1);
    transmit();
    expect_v("R4", 0, 0, 0, 0, 1);
  endtask

  task automatic t_saturate();  // R9 with CRC and alignment errors together
    for (int f = 0; f < 15; f++) begin
      put_lead(); put_body(2, 40 + f, 32'h0001_0000); put_tail(4);
      transmit();
      expect_v("R9", 0, 0, 1, 1, 0);
    end
    chk("R9", "crc_err_cnt ceiling", int'(crc_err_cnt), CNT_MAX);
    chk("R9", "align_err_cnt ceiling", int'(align_err_cnt), CNT_MAX);
  endtask

  initial begin
    rst_n = 1'b0; carrier = 1'b0; rx_strobe = 1'b0; rx_bit = 1'b0;
    rx_with_errors = 1'b0; wire_len = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good();
    t_good_tail(1);
    t_good_tail(5);
    t_bad(0);
    t_bad(1);
    t_bad(3);
    t_bad(7);
    t_keep();
    t_abort_mid();
    t_abort_start();
    t_drop_lead();
    t_good();
    t_saturate();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule